// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a simple synchronous request port and an external asynchronous static RAM holding 131,072 bytes (17 address bits, 8 data bits). An internal client presents a request with a read/write flag, an address and, for writes, a byte. The sequencer turns that request into a timed pattern of chip selects, output enable and write enable on the memory pins. It counts whole clock cycles so that every access lasts at least the memory's access time, which defaults to 70 ns.

The memory's data lines are shared. The controller has separate outgoing data, incoming data and a drive-enable for its own output buffers. It hands the bus over explicitly: it turns its buffers on only while the memory's output enable is inactive, and it never asks the memory to drive while its own buffers are on. The memory has two selects of opposite polarity. Both are asserted for the duration of an access and both are released whenever the controller is idle, so the memory can drop into its low-power state.

A read returns the captured byte with a one-cycle valid pulse. A ready flag tells the client when a new request will be taken. Any request presented while ready is low is discarded.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ready is 1, rsp_valid is 0, sram_sel_n is 1, sram_sel is 0, sram_rd_en_n is 1, sram_wr_en_n is 1 and sram_drive is 0.
- R2: Whenever the controller is idle (ready is 1), both selects are inactive (sram_sel_n = 1, sram_sel = 0), both strobes are high and sram_drive is 0.
- R3: A write accepted at a clock edge starts with exactly one setup cycle. In that cycle both selects are active, the address is driven, sram_wr_en_n is 1 and sram_drive is 1. The setup cycle is followed by the write pulse with sram_wr_en_n at 0.
- R4: sram_rd_en_n stays 1 for every cycle of a write. sram_drive is never 1 in a cycle where sram_rd_en_n is 0.
- R5: A read accepted at a clock edge holds both selects active and sram_rd_en_n at 0, with sram_wr_en_n at 1 and sram_drive at 0, for exactly N consecutive cycles starting in the next cycle.
- R6: In the cycle after the last read cycle, rsp_valid is 1 for exactly one cycle. In that cycle rsp_rdata equals the byte that was on sram_din during the last read cycle.
- R7: A request is accepted only at an edge where ready is 1. ready stays 0 from the cycle after acceptance until the controller is idle again. A request presented while ready is 0 has no effect on the strobes, the address or the memory contents.
- R8: N equals the access time divided by the clock period, rounded up, with a minimum of 1. With the defaults (70000 ps and 4000 ps) N is 18, and the write pulse lasts exactly N cycles.
- R9: sram_addr does not change while the selects stay active, and it equals the accepted request's address.
- R10: After the write pulse there is exactly one hold cycle with sram_wr_en_n at 1, the selects still active and sram_drive at 1. Throughout the write, sram_dout equals the accepted byte. The controller is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle, request will be taken |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Captured read byte |
| sram_sel_n | output | 1 | Memory select, active low |
| sram_sel | output | 1 | Memory select, active high |
| sram_rd_en_n | output | 1 | Memory output enable, active low |
| sram_wr_en_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | 17 | Memory address bus |
| sram_dout | output | 8 | Data driven toward the memory |
| sram_drive | output | 1 | Enable of the controller's data buffers |
| sram_din | input | 8 | Data received from the memory |

## Verification
A wrong sequencer state shows up at the pins in the very next cycle. It appears as a strobe pattern that differs from the expected setup, pulse, hold or read window, as ready out of step with the selects, or as drive overlapping output enable. A miscounting timer keeps the same strobe shapes but changes how long the write pulse or read window lasts, so the error becomes visible at the edge where the window should have closed. A faulty capture path only shows in the valid cycle, as rsp_rdata that differs from the byte the memory model presented in the last read cycle.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_WHOLD   = 3'd3,
    ST_RACCESS = 3'd4
  } ctl_state_t;

  // Whole clock cycles covering the access time, never below one.
  function automatic int unsigned access_cycles(input int unsigned clk_ps,
                                                input int unsigned acc_ps);
    int unsigned n;
    n = (acc_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  // Width of a down-counter that must hold n-1.
  function automatic int unsigned count_width(input int unsigned n);
    int unsigned w;
    w = (n > 1) ? $clog2(n) : 1;
    return w;
  endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic tmr_done,
  output logic accept,
  output logic capture,
  output logic tmr_load,
  output logic ready,
  output logic sel_n,
  output logic sel,
  output logic rd_en_n,
  output logic wr_en_n,
  output logic drive
);

  ctl_state_t state, nxt;

  always_comb begin
    nxt      = state;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          nxt      = req_write ? ST_WSETUP : ST_RACCESS;
        end
      end
      ST_WSETUP: begin
        tmr_load = 1'b1;
        nxt      = ST_WPULSE;
      end
      ST_WPULSE: begin
        if (tmr_done) nxt = ST_WHOLD;
      end
      ST_WHOLD: begin
        nxt = ST_IDLE;
      end
      ST_RACCESS: begin
        if (tmr_done) begin
          capture = 1'b1;
          nxt     = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // Pin levels decoded from the registered state.
  assign ready   = (state == ST_IDLE);
  assign sel_n   = (state == ST_IDLE);
  assign sel     = (state != ST_IDLE);
  assign rd_en_n = (state != ST_RACCESS);
  assign wr_en_n = (state != ST_WPULSE);
  assign drive   = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] sram_din,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= sram_din;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned AW     = 17,
  parameter int unsigned DW     = 8,
  parameter int unsigned CLK_PS = 4000,
  parameter int unsigned ACC_PS = 70000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sram_sel_n,
  output logic          sram_sel,
  output logic          sram_rd_en_n,
  output logic          sram_wr_en_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dout,
  output logic          sram_drive,
  input  logic [DW-1:0] sram_din
);

  localparam int unsigned ACCESS_N = access_cycles(CLK_PS, ACC_PS);
  localparam int unsigned CNT_W    = count_width(ACCESS_N);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(ACCESS_N - 1);

  // Named internal events, visible to the bound checker.
  logic accept;
  logic capture;
  logic tmr_load;
  logic tmr_done;

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (LOAD_VAL),
    .done     (tmr_done)
  );

  asram_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_done  (tmr_done),
    .accept    (accept),
    .capture   (capture),
    .tmr_load  (tmr_load),
    .ready     (ready),
    .sel_n     (sram_sel_n),
    .sel       (sram_sel),
    .rd_en_n   (sram_rd_en_n),
    .wr_en_n   (sram_wr_en_n),
    .drive     (sram_drive)
  );

  asram_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sram_din  (sram_din),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dout),
    .rdata_q   (rsp_rdata),
    .rvalid_q  (rsp_valid)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk
  import asram_pkg::*;
#(
  parameter int unsigned AW     = 17,
  parameter int unsigned DW     = 8,
  parameter int unsigned CLK_PS = 4000,
  parameter int unsigned ACC_PS = 70000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rsp_valid,
  input logic          sram_sel_n,
  input logic          sram_sel,
  input logic          sram_rd_en_n,
  input logic          sram_wr_en_n,
  input logic [AW-1:0] sram_addr,
  input logic [DW-1:0] sram_dout,
  input logic          sram_drive,
  input logic          accept,
  input logic          capture
);

  localparam int unsigned ACCESS_N = access_cycles(CLK_PS, ACC_PS);
  localparam int unsigned PW       = $clog2(ACCESS_N + 2);

  logic [PW-1:0] wr_low;
  logic [PW-1:0] rd_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low <= '0;
      rd_low <= '0;
    end else begin
      wr_low <= sram_wr_en_n ? '0 : wr_low + 1'b1;
      rd_low <= sram_rd_en_n ? '0 : rd_low + 1'b1;
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sram_sel_n && !sram_sel && sram_rd_en_n && sram_wr_en_n && !sram_drive)); // R2
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    sram_drive |-> sram_rd_en_n); // R4
  AST_NO_RD_IN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_wr_en_n |-> sram_rd_en_n); // R4
  AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_wr_en_n) |-> ($past(!sram_sel_n) && $past(sram_drive) && $past(sram_rd_en_n))); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_wr_en_n) |-> (!sram_sel_n && sram_drive)); // R10
  AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_wr_en_n) |-> (wr_low == PW'(ACCESS_N))); // R8
  AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_rd_en_n) |-> (rd_low == PW'(ACCESS_N))); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_sel_n && $past(!sram_sel_n)) |-> $stable(sram_addr)); // R9
  AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_drive && $past(sram_drive)) |-> $stable(sram_dout)); // R10
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_CAPTURE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> rsp_valid); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_sel_n |-> !ready); // R7
  AST_ACCEPT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ready); // R7

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_PS(CLK_PS), .ACC_PS(ACC_PS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ready        (ready),
  .rsp_valid    (rsp_valid),
  .sram_sel_n   (sram_sel_n),
  .sram_sel     (sram_sel),
  .sram_rd_en_n (sram_rd_en_n),
  .sram_wr_en_n (sram_wr_en_n),
  .sram_addr    (sram_addr),
  .sram_dout    (sram_dout),
  .sram_drive   (sram_drive),
  .accept       (accept),
  .capture      (capture)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  // R8: own rounding of 70 ns over a 4 ns clock, expected 18.
  localparam int NCYC  = (70000 + 4000 - 1) / 4000;
  localparam logic [7:0] FLOAT = 8'hC3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        sram_sel_n, sram_sel, sram_rd_en_n, sram_wr_en_n, sram_drive;
  logic [16:0] sram_addr;
  logic [7:0]  sram_dout;
  logic [7:0]  sram_din = FLOAT;

  always #2 clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_sel_n(sram_sel_n),
    .sram_sel(sram_sel), .sram_rd_en_n(sram_rd_en_n), .sram_wr_en_n(sram_wr_en_n),
    .sram_addr(sram_addr), .sram_dout(sram_dout), .sram_drive(sram_drive),
    .sram_din(sram_din)
  );

  // Behavioural memory on the pins.
  logic [7:0] sram_mem [int];
  always @(negedge clk) begin
    if (rst_n && !sram_sel_n && sram_sel && !sram_wr_en_n && sram_drive)
      sram_mem[int'(sram_addr)] = sram_dout;
  end
  always @(posedge clk) begin
    #1;
    if (!sram_sel_n && sram_sel && !sram_rd_en_n && sram_wr_en_n)
      sram_din = sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : 8'h00;
    else
      sram_din = FLOAT;
  end

  // Reference model: queue of expected per-cycle pin values.
  typedef struct packed {
    logic [4:0]  strobes;   // sel_n, sel, rd_en_n, wr_en_n, drive
    logic        rdy;
    logic        rv;
    logic [16:0] a;
    logic        ac;
    logic [7:0]  wd;
    logic        wc;
    logic [7:0]  rd;
    logic [3:0]  tag;
  } exp_t;

  exp_t       expq [$];
  logic [7:0] ref_mem [int];
  int checks = 0;
  int errors = 0;
  bit accepted;
  bit finished = 0;

  function automatic string tname(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd8:    return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic exp_t mk(input logic [4:0] s, input logic rdy, input logic rv,
                              input logic [16:0] a, input logic ac, input logic [7:0] wd,
                              input logic wc, input logic [7:0] rd, input logic [3:0] tag);
    exp_t e;
    e.strobes = s; e.rdy = rdy; e.rv = rv; e.a = a; e.ac = ac;
    e.wd = wd; e.wc = wc; e.rd = rd; e.tag = tag;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input exp_t e);
    logic [4:0] s;
    s = {sram_sel_n, sram_sel, sram_rd_en_n, sram_wr_en_n, sram_drive};
    chk(s === e.strobes, tname(e.tag), "strobes", 32'(s), 32'(e.strobes));
    chk(ready === e.rdy, "R7", "ready", 32'(ready), 32'(e.rdy));
    chk(!(sram_drive && !sram_rd_en_n), "R4", "drive during output enable", 32'(sram_drive), 0);
    if (e.ac) chk(sram_addr === e.a, "R9", "address", 32'(sram_addr), 32'(e.a));
    if (e.wc) chk(sram_dout === e.wd, "R10", "write data", 32'(sram_dout), 32'(e.wd));
    chk(rsp_valid === e.rv, "R6", "rsp_valid", 32'(rsp_valid), 32'(e.rv));
    if (e.rv) chk(rsp_rdata === e.rd, "R6", "rsp_rdata", 32'(rsp_rdata), 32'(e.rd));
  endtask

  // One cycle: check the current cycle, then drive inputs for the next edge.
  task automatic step(input logic v, input logic w, input logic [16:0] a, input logic [7:0] d);
    exp_t cur;
    logic [7:0] rb;
    @(negedge clk);
    cur = (expq.size() != 0) ? expq.pop_front()
                             : mk(5'b10110, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0, 4'd2);
    compare(cur);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    accepted = 1'b0;
    if (v && cur.rdy) begin   // R7: only taken while ready
      accepted = 1'b1;
      if (w) begin
        expq.push_back(mk(5'b01111, 1'b0, 1'b0, a, 1'b1, d, 1'b1, '0, 4'd3));
        for (int i = 0; i < NCYC; i++)
          expq.push_back(mk(5'b01101, 1'b0, 1'b0, a, 1'b1, d, 1'b1, '0, 4'd8));
        expq.push_back(mk(5'b01111, 1'b0, 1'b0, a, 1'b1, d, 1'b1, '0, 4'd10));
        ref_mem[int'(a)] = d;
      end else begin
        rb = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
        for (int i = 0; i < NCYC; i++)
          expq.push_back(mk(5'b01010, 1'b0, 1'b0, a, 1'b1, '0, 1'b0, '0, 4'd5));
        expq.push_back(mk(5'b10110, 1'b1, 1'b1, '0, 1'b0, '0, 1'b0, rb, 4'd6));
      end
    end
  endtask

  task automatic issue(input logic w, input logic [16:0] a, input logic [7:0] d);
    accepted = 1'b0;
    while (!accepted) step(1'b1, w, a, d);
  endtask

  task automatic drain();
    while (expq.size() != 0) step(1'b0, 1'b0, '0, '0);
    step(1'b0, 1'b0, '0, '0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] lfsr;
    logic [7:0]  dd;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk(ready === 1'b1 && rsp_valid === 1'b0, "R1", "ready/valid in reset",
        32'({ready, rsp_valid}), 32'b10);
    chk({sram_sel_n, sram_sel, sram_rd_en_n, sram_wr_en_n, sram_drive} === 5'b10110,
        "R1", "strobes in reset",
        32'({sram_sel_n, sram_sel, sram_rd_en_n, sram_wr_en_n, sram_drive}), 32'b10110);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, '0, '0);   // R1, R2: idle after reset

    // R3, R8, R10: basic write, then R5, R6 read back
    issue(1'b1, 17'h00010, 8'h5A);
    drain();
    issue(1'b0, 17'h00010, 8'h00);
    drain();
    // Address extremes, back to back with request held high
    issue(1'b1, 17'h1FFFF, 8'h81);
    issue(1'b1, 17'h00000, 8'h7E);
    issue(1'b0, 17'h1FFFF, 8'h00);
    issue(1'b0, 17'h00000, 8'h00);
    drain();
    // R5, R6: read of a never-written location returns the memory's 00
    issue(1'b0, 17'h0ABCD, 8'h00);
    drain();
    // R7: request while busy is ignored; location 0x00011 must stay unwritten
    issue(1'b1, 17'h00020, 8'h11);
    step(1'b1, 1'b1, 17'h00011, 8'h33);
    step(1'b1, 1'b0, 17'h00012, 8'h44);
    step(1'b0, 1'b0, '0, '0);
    drain();
    issue(1'b0, 17'h00011, 8'h00);
    drain();
    issue(1'b0, 17'h00020, 8'h00);
    drain();
    // Mixed patterns
    lfsr = 32'h1D2C3B4A;
    for (int i = 0; i < 24; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      dd = lfsr[15:8];
      if (dd == FLOAT) dd = 8'h3C;
      issue(lfsr[0], {13'h0, lfsr[20:17]}, dd);
      if (lfsr[3]) step(1'b0, 1'b0, '0, '0);
    end
    drain();
    for (int i = 0; i < 16; i++) issue(1'b0, 17'(i), 8'h00);
    drain();
    summary();
  end

endmodule